// File: doc/BRIEF.md
# Banked Per-CPU Interrupt Aggregator

This block is a first-level interrupt collector. It takes a vector of level-sensitive peripheral interrupt sources, passes them through a two-flop synchronizer, and presents them to one or two processors. Each processor has its own register bank on a simple 32-bit read/write bus. A bank holds one enable word per group of 32 sources and one read-only status word per group. The bank raises its own upstream interrupt line whenever a synchronized source is both pending and enabled in that bank.

Software routes a source to a processor by setting its bit in that processor's enable word. The whole word is rewritten each time, because there are no separate set or clear addresses. In normal use a source is enabled in only one bank. The parameters choose 2 or 4 words per bank (64 or 128 sources) and 1 or 2 banks.

The address decoder classifies every access as one of three regions, using an enumerated type with a unique case. An enable access hits a bank's enable word. A status access hits the shared synchronized source word. A none access falls outside the last bank. There is no sequential protocol state: a read always completes in one cycle.

Top module: `irq_bank_aggr`

## Requirements
- R1: After reset every enable word is zero, every `cpu_irq` bit is 0 and `bus_rdata` is 0.
- R2: Bank b starts at byte address b*N_WORDS*8. Within a bank, the first N_WORDS words (byte offsets 0, 4, ...) are enable words, and the next N_WORDS words are status words. The low two address bits are ignored.
- R3: Word ordering is reversed in both regions. The word at region word index k covers sources (N_WORDS-1-k)*32 to (N_WORDS-1-k)*32+31. Source s of that group sits at bit s mod 32. With 4 words, the status word at bank offset 0x10 holds sources 96..127, and the one at 0x1C holds sources 0..31.
- R4: A write to an enable address replaces all 32 bits of that enable word. A later read of the same address returns the written value.
- R5: Each bank's enable words are independent. A write to one bank leaves the enable words of every other bank unchanged.
- R6: `cpu_irq[b]` is a register holding the OR of (synchronized sources AND bank b's enables). It changes one clock after an enable write, and three clocks after a change on `src_irq`.
- R7: A status read returns the synchronized level of the sources. A write to a status address changes nothing.
- R8: Any address at or above N_BANKS*N_WORDS*8 reads as zero, and a write to it changes nothing.
- R9: `bus_rdata` is loaded on the clock edge where `bus_sel`=1 and `bus_wr`=0. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq | input | N_WORDS*32 | Level interrupt sources, asynchronous |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| cpu_irq | output | N_BANKS | Upstream interrupt, one per processor bank |

## Verification
A corrupted enable bit shows up in two ways. The next read of that word returns the wrong value, and within one clock the bank's interrupt line is asserted or dropped wrongly whenever the matching source is active. A decoder that mixes up the word order or the bank stride returns swapped status groups on the very next read. It also makes an enable write arm the wrong group of sources, which shows on `cpu_irq` one clock later. A synchronizer with the wrong depth moves the edge of `cpu_irq` away from the third clock after a source change. The bench checks that exact cycle.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
    localparam int WORD_BITS = 32;

    typedef enum logic [1:0] {
        REGION_NONE   = 2'd0,
        REGION_ENABLE = 2'd1,
        REGION_STATUS = 2'd2
    } region_e;
endpackage

// File: rtl/intagg_sync.sv
module intagg_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/intagg_bank.sv
module intagg_bank #(
    parameter int N_WORDS = 4,
    localparam int LW_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int N_SRC  = N_WORDS * intagg_pkg::WORD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LW_W-1:0]  wr_word,
    input  logic [31:0]      wr_data,
    input  logic [N_SRC-1:0] status_sync,
    output logic [N_SRC-1:0] en_flat,
    output logic             irq_q
);
    logic [N_WORDS-1:0][31:0] en_q;

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[w] <= '0;
            end else if (wr_en && (wr_word == LW_W'(w))) begin
                en_q[w] <= wr_data;
            end
        end

        p_enable_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_word == LW_W'(w))) |=> (en_q[w] == $past(wr_data)));
    end

    assign en_flat = en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_sync & en_flat);
        end
    end

    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_flat));
endmodule

// File: rtl/irq_bank_aggr.sv
module irq_bank_aggr #(
    parameter int N_WORDS = 4,
    parameter int N_BANKS = 2,
    parameter int ADDR_W  = 8,
    localparam int N_SRC      = N_WORDS * intagg_pkg::WORD_BITS,
    localparam int LW_W       = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
    localparam int WIDX_W     = $clog2(2 * N_WORDS),
    localparam int BANK_SHIFT = $clog2(N_WORDS * 8),
    localparam int BSEL_W     = ADDR_W - BANK_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_irq,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [N_BANKS-1:0] cpu_irq
);
    import intagg_pkg::*;

    logic [N_SRC-1:0]              status_sync;
    logic [N_BANKS-1:0][N_SRC-1:0] en_all;
    logic [N_BANKS-1:0]            bank_hit;
    logic [N_BANKS-1:0]            bank_wr;
    logic [WIDX_W-1:0]             word_idx;
    logic [BSEL_W-1:0]             bank_idx;
    logic [LW_W-1:0]               lw;
    logic                          in_range;
    region_e                       region;
    logic [31:0]                   rd_word;
    logic [31:0]                   en_word;

    intagg_sync #(.WIDTH(N_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_irq),
        .sync_out (status_sync)
    );

    assign word_idx = bus_addr[BANK_SHIFT-1:2];
    assign bank_idx = bus_addr[ADDR_W-1:BANK_SHIFT];

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        assign bank_hit[b] = (bank_idx == BSEL_W'(b));
        assign bank_wr[b]  = bus_sel && bus_wr && bank_hit[b] && (region == REGION_ENABLE);

        intagg_bank #(.N_WORDS(N_WORDS)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (bank_wr[b]),
            .wr_word     (lw),
            .wr_data     (bus_wdata),
            .status_sync (status_sync),
            .en_flat     (en_all[b]),
            .irq_q       (cpu_irq[b])
        );

        p_irq_needs_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cpu_irq[b]) |-> $past(|status_sync));
    end

    assign in_range = |bank_hit;

    // Region classification and reversed word numbering
    always_comb begin
        if (!in_range) begin
            region = REGION_NONE;
        end else if (32'(word_idx) < N_WORDS) begin
            region = REGION_ENABLE;
        end else begin
            region = REGION_STATUS;
        end
        lw = LW_W'(N_WORDS - 1) - word_idx[LW_W-1:0];
    end

    always_comb begin
        en_word = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (bank_hit[b]) begin
                en_word = en_word | en_all[b][{lw, 5'b0} +: 32];
            end
        end
    end

    always_comb begin
        unique case (region)
            REGION_ENABLE: rd_word = en_word;
            REGION_STATUS: rd_word = status_sync[{lw, 5'b0} +: 32];
            REGION_NONE:   rd_word = '0;
            default:       rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_sel && !bus_wr) begin
            bus_rdata <= rd_word;
        end
    end

    p_status_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && region == REGION_STATUS) |=> $stable(en_all));

    p_oob_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && region == REGION_NONE) |=> $stable(en_all));

    p_oob_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && region == REGION_NONE) |=> (bus_rdata == 32'h0));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

// File: tb/irq_bank_aggr_bench.sv
`timescale 1ns/1ps
module irq_bank_aggr_bench;
    localparam int N_WORDS = 4;
    localparam int N_BANKS = 2;
    localparam int ADDR_W  = 8;
    localparam int N_SRC   = N_WORDS * 32;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_SRC-1:0]   src_irq = '0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [31:0]        bus_wdata = '0;
    logic [31:0]        bus_rdata;
    logic [N_BANKS-1:0] cpu_irq;

    int       n_checks = 0;
    int       n_fails = 0;
    rd_item_t sb[$];
    logic     rd_due = 1'b0;

    always #2.5 clk = ~clk;

    irq_bank_aggr #(.N_WORDS(N_WORDS), .N_BANKS(N_BANKS), .ADDR_W(ADDR_W)) u_irq_bank_aggr (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq)
    );

    // Monitor: pop expected read data once the read has been registered
    always @(posedge clk) rd_due <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (rd_due) begin
            rd_item_t it;
            it = sb.pop_front();
            n_checks++;
            if (bus_rdata !== it.exp) begin
                n_fails++;
                $display("FAIL %s: rdata actual %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic [N_BANKS-1:0] e, input string tag);
        n_checks++;
        if (cpu_irq !== e) begin
            n_fails++;
            $display("FAIL %s: cpu_irq actual %b expected %b", tag, cpu_irq, e);
        end
    endtask

    task automatic chk_rdata(input logic [31:0] e, input string tag);
        n_checks++;
        if (bus_rdata !== e) begin
            n_fails++;
            $display("FAIL %s: rdata actual %h expected %h", tag, bus_rdata, e);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_irq(2'b00, "R1 irq after reset");
        chk_rdata(32'h0, "R1 rdata after reset");
        for (int b = 0; b < N_BANKS; b++) begin
            for (int k = 0; k < N_WORDS; k++) begin
                bus_read(ADDR_W'(b * 32 + k * 4), 32'h0, "R1 enable zero");
            end
        end

        // R3 R7 R2 status ordering, both banks
        src_irq = {32'hD000_0004, 32'hC000_0003, 32'hB000_0002, 32'hA000_0001};
        repeat (4) @(negedge clk);
        bus_read(8'h10, 32'hD000_0004, "R3 status off10 src96-127");
        bus_read(8'h14, 32'hC000_0003, "R3 status off14 src64-95");
        bus_read(8'h18, 32'hB000_0002, "R7 status off18 src32-63");
        bus_read(8'h1C, 32'hA000_0001, "R3 status off1C src0-31");
        bus_read(8'h30, 32'hD000_0004, "R2 bank1 status off30");
        bus_read(8'h3E, 32'hA000_0001, "R2 bank1 status off3C low bits ignored");
        chk_irq(2'b00, "R6 no enables no irq");

        // R4 R6 enable write on bank0 word for src0-31
        bus_write(8'h0C, 32'h0000_0001);
        chk_irq(2'b00, "R6 irq not yet after enable write");
        @(negedge clk);
        chk_irq(2'b01, "R6 irq one clock after enable write");
        bus_read(8'h0C, 32'h0000_0001, "R4 enable readback");
        bus_read(8'h2C, 32'h0000_0000, "R5 bank1 untouched");

        // R3 bank1 enable word at offset 0 covers src96-127 (bit 98)
        bus_write(8'h20, 32'h0000_0004);
        @(negedge clk);
        chk_irq(2'b11, "R3 bank1 src98 via top word");
        bus_read(8'h00, 32'h0000_0000, "R5 bank0 word unaffected by bank1 write");

        // R4 whole-word rewrite drops src0 enable
        bus_write(8'h0C, 32'h0000_0002);
        @(negedge clk);
        chk_irq(2'b10, "R4 rewrite clears previous enable");

        // R7 status write ignored
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_read(8'h10, 32'hD000_0004, "R7 status unchanged after write");
        bus_read(8'h00, 32'h0000_0000, "R7 enable unchanged after status write");
        chk_irq(2'b10, "R7 irq unchanged after status write");

        // R8 out of range
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        bus_read(8'h40, 32'h0, "R8 oob read zero");
        bus_read(8'h7C, 32'h0, "R8 oob read zero high");
        bus_read(8'h20, 32'h0000_0004, "R8 bank1 enable unchanged");
        bus_read(8'h0C, 32'h0000_0002, "R8 bank0 enable unchanged");
        chk_irq(2'b10, "R8 irq unchanged");

        // R6 source drop takes three clocks
        @(negedge clk);
        src_irq[98] = 1'b0;
        @(negedge clk);
        chk_irq(2'b10, "R6 source drop +1");
        @(negedge clk);
        chk_irq(2'b10, "R6 source drop +2");
        @(negedge clk);
        chk_irq(2'b00, "R6 source drop +3");

        // R9 read data holds
        bus_read(8'h20, 32'h0000_0004, "R9 read");
        repeat (3) @(negedge clk);
        chk_rdata(32'h0000_0004, "R9 rdata holds while idle");
        bus_write(8'h08, 32'h1234_5678);
        chk_rdata(32'h0000_0004, "R9 rdata holds across write");

        // R4 full word on src64-95 group
        bus_write(8'h04, 32'hFFFF_FFFF);
        @(negedge clk);
        chk_irq(2'b01, "R4 full enable word src64-95");
        bus_read(8'h04, 32'hFFFF_FFFF, "R4 full word readback");
        bus_read(8'h08, 32'h1234_5678, "R4 word src32-63 readback");

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9: pending reads actual %0d expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule